// File: doc/BRIEF.md
# Serialized Interrupt Slave Encoder

This block sits on the peripheral side of a one-wire serialized interrupt line that advances one state per bus clock. It watches the shared open-drain line for the start of an interrupt cycle. It then walks a fixed sequence of frames and signals each asserted request by pulling the line low in that request's slot. After each low drive it actively restores the line high for one state and then lets go of it.

Each cycle ends with a stop frame from the host. The number of low states in the stop frame sets whether the next cycle is quiet or continuous. In continuous mode only the host opens a cycle. In quiet mode the block may open a cycle itself, by pulling the line low for a single state, when its requests differ from the ones it last reported. The pad is modelled as an output-enable plus an output value. The line level is sampled on every clock.

Top module: `serirq_slave`

## Requirements
- R1: Reset puts the block in idle with the line released (serOe low) and in continuous mode. A request change in that state causes no drive.
- R2: While idle, a low sample on serIn opens a cycle whose start frame is 6 states, counting the low state as the first. The first data slot is the 7th state. A host start wins over a pending self-start in the same state.
- R3: Data frame n (n = 1..17) uses request bit n-1, so the SMI slot is frame 3 and uses bit 2. Each frame is 3 states. For an asserted bit: state 0 drives low, state 1 drives high, state 2 releases.
- R4: When a request bit is low, the block releases the line for all 3 states of that slot.
- R5: Bit 0 (IRQ0 slot, frame 1) and bit 16 (IOCHCK slot, frame 17) are never driven, whatever their value.
- R6: Requests are captured when the cycle opens. A change during the cycle does not alter that cycle's slots.
- R7: The stop frame follows frame 17. It holds one or more released states, then host low states, then a high state. Exactly 2 lows select quiet mode. 3 or more lows select continuous mode. A single low leaves the mode unchanged.
- R8: In quiet mode, with the block idle and serIn high, a difference between the current requests and the last captured ones makes the block drive low for exactly one state. That state is the first start state. The host drives the rest of the start frame.
- R9: No self-start happens in continuous mode, or in quiet mode when the requests are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, one line state per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 17 | Level requests, bit n-1 belongs to data frame n |
| serIn | input | 1 | Sampled level of the shared line |
| serOe | output | 1 | Line drive enable |
| serOut | output | 1 | Line drive value when enabled |

## Verification
The bench models the host and the wired line, and checks the slave's drive in every state. It looks for an off-by-one start length: that would shift every slot and put the low pulses in the wrong frame. It sets requests on bits 0 and 16, where a design that decoded every bit would drive the IRQ0 or IOCHCK slot. It changes requests during a cycle; a design without a capture register would report the new value at once. It also varies the stop-frame length. A design that decoded the mode wrongly would self-start in continuous mode, or stay silent in quiet mode. If the host and the slave both start in the same state, a design without priority would emit a stray self-start pulse.

// File: rtl/serirq_pkg.sv
package serirq_pkg;

  localparam int SLOT_IDX_W = 5;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SELF,
    PH_START,
    PH_DATA,
    PH_STOP
  } phase_e;

  // Control-to-datapath strobes, decoded from the control registers.
  typedef struct packed {
    logic                  capture;
    logic                  selfDrive;
    logic                  slotDrive;
    logic                  slotRecover;
    logic [SLOT_IDX_W-1:0] slotIdx;
  } strobe_t;

endpackage

// File: rtl/serirq_ctrl.sv
module serirq_ctrl
  import serirq_pkg::*;
#(
  parameter int NUM_SLOTS    = 17,
  parameter int START_STATES = 6,
  parameter int SLOT_STATES  = 3,
  parameter int QUIET_LOWS   = 2,
  parameter int CONT_LOWS    = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serIn,
  input  logic    changePending,
  output strobe_t strobe
);

  localparam int ST_MAX = (START_STATES > SLOT_STATES) ? START_STATES : SLOT_STATES;
  localparam int ST_W   = $clog2(ST_MAX);
  localparam int FR_W   = $clog2(NUM_SLOTS + 1);
  localparam int LOW_W  = $clog2(CONT_LOWS + 1);

  phase_e           phase;
  logic [ST_W-1:0]  stCnt;
  logic [FR_W-1:0]  frameCnt;
  logic [LOW_W-1:0] lowCnt;
  logic             quietMode;
  logic             hostStart;
  logic             selfStart;

  assign hostStart = (phase == PH_IDLE) && !serIn;
  assign selfStart = (phase == PH_IDLE) && serIn && quietMode && changePending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      stCnt     <= '0;
      frameCnt  <= '0;
      lowCnt    <= '0;
      quietMode <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (hostStart) begin
            phase <= PH_START;
            stCnt <= ST_W'(1);
          end else if (selfStart) begin
            phase <= PH_SELF;
          end
        end
        PH_SELF: begin
          phase <= PH_START;
          stCnt <= ST_W'(1);
        end
        PH_START: begin
          if (stCnt == ST_W'(START_STATES - 1)) begin
            phase    <= PH_DATA;
            stCnt    <= '0;
            frameCnt <= FR_W'(1);
          end else begin
            stCnt <= stCnt + ST_W'(1);
          end
        end
        PH_DATA: begin
          if (stCnt == ST_W'(SLOT_STATES - 1)) begin
            stCnt <= '0;
            if (frameCnt == FR_W'(NUM_SLOTS)) begin
              phase  <= PH_STOP;
              lowCnt <= '0;
            end else begin
              frameCnt <= frameCnt + FR_W'(1);
            end
          end else begin
            stCnt <= stCnt + ST_W'(1);
          end
        end
        PH_STOP: begin
          if (!serIn) begin
            if (lowCnt != LOW_W'(CONT_LOWS)) lowCnt <= lowCnt + LOW_W'(1);
          end else if (lowCnt != '0) begin
            phase <= PH_IDLE;
            if (lowCnt == LOW_W'(QUIET_LOWS))     quietMode <= 1'b1;
            else if (lowCnt == LOW_W'(CONT_LOWS)) quietMode <= 1'b0;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe             = '0;
    strobe.capture     = hostStart || selfStart;
    strobe.selfDrive   = (phase == PH_SELF);
    strobe.slotDrive   = (phase == PH_DATA) && (stCnt == '0);
    strobe.slotRecover = (phase == PH_DATA) && (stCnt == ST_W'(1));
    strobe.slotIdx     = SLOT_IDX_W'(frameCnt - FR_W'(1));
  end

  AST_START_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DATA && frameCnt == FR_W'(1) && stCnt == '0) |-> $past(phase) == PH_START); // R2

  AST_SELF_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SELF) |-> quietMode); // R9

  AST_SELF_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SELF) |=> (phase == PH_START)); // R8

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(phase) == PH_STOP && phase == PH_IDLE && $past(lowCnt) == LOW_W'(QUIET_LOWS)) |-> quietMode); // R7

endmodule

// File: rtl/serirq_datapath.sv
module serirq_datapath
  import serirq_pkg::*;
#(
  parameter int                   NUM_SLOTS   = 17,
  parameter logic [NUM_SLOTS-1:0] SLOT_ENABLE = '1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] reqIn,
  input  strobe_t              strobe,
  output logic                 changePending,
  output logic                 serOe,
  output logic                 serOut
);

  logic [NUM_SLOTS-1:0] driveMask;
  logic [NUM_SLOTS-1:0] reqMasked;
  logic [NUM_SLOTS-1:0] snap;
  logic                 slotBit;

  // The first and last slots are reserved and never driven.
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_mask
    if (i == 0 || i == NUM_SLOTS - 1) begin : g_fixed
      assign driveMask[i] = 1'b0;
    end else begin : g_open
      assign driveMask[i] = SLOT_ENABLE[i];
    end
  end

  assign reqMasked     = reqIn & driveMask;
  assign changePending = (reqMasked != snap);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) snap <= '0;
    else if (strobe.capture) snap <= reqMasked;
  end

  assign slotBit = snap[strobe.slotIdx];
  assign serOe   = strobe.selfDrive || ((strobe.slotDrive || strobe.slotRecover) && slotBit);
  assign serOut  = strobe.slotRecover;

  AST_RECOVER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.slotDrive && serOe) |=> (serOe && serOut)); // R3

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rstN)
    (serOe && serOut) |=> !serOe); // R3

  AST_RESERVED_SLOTS: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.slotDrive || strobe.slotRecover) &&
     (strobe.slotIdx == '0 || strobe.slotIdx == SLOT_IDX_W'(NUM_SLOTS - 1))) |-> !serOe); // R5

  AST_SELF_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.selfDrive |=> !strobe.selfDrive); // R8

endmodule

// File: rtl/serirq_slave.sv
module serirq_slave
  import serirq_pkg::*;
#(
  parameter int NUM_SLOTS    = 17,
  parameter int START_STATES = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_SLOTS-1:0] reqIn,
  input  logic                 serIn,
  output logic                 serOe,
  output logic                 serOut
);

  strobe_t strobe;
  logic    changePending;

  serirq_ctrl #(
    .NUM_SLOTS   (NUM_SLOTS),
    .START_STATES(START_STATES)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .serIn        (serIn),
    .changePending(changePending),
    .strobe       (strobe)
  );

  serirq_datapath #(
    .NUM_SLOTS(NUM_SLOTS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .reqIn        (reqIn),
    .strobe       (strobe),
    .changePending(changePending),
    .serOe        (serOe),
    .serOut       (serOut)
  );

endmodule

// File: tb/serirq_slave_bench.sv
`timescale 1ns/1ps
module serirq_slave_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [16:0] reqIn = '0;
  logic        hostLow = 1'b0;
  logic        serIn;
  logic        serOe;
  logic        serOut;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  typedef struct {
    logic  oe;
    logic  out;
    string tag;
  } exp_t;

  exp_t expQ[$];

  always #4 clk = ~clk;

  assign serIn = !((serOe && !serOut) || hostLow);

  serirq_slave u_serirq_slave (
    .clk   (clk),
    .rstN  (rstN),
    .reqIn (reqIn),
    .serIn (serIn),
    .serOe (serOe),
    .serOut(serOut)
  );

  // Driver: one call per line state, pushing the expected slave drive.
  task automatic step(input logic low, input logic eOe, input logic eOut, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    hostLow = low;
    e.oe  = eOe;
    e.out = eOut;
    e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compares each state's drive in mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        checks++;
        if (serOe !== e.oe || (e.oe && serOut !== e.out)) begin
          errors++;
          $display("FAIL %s: oe/out actual %b/%b expected %b/%b", e.tag, serOe, serOut, e.oe, e.out);
        end
      end
    end
  end

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, tag);
  endtask

  // Start states 1..5 after the first low state.
  task automatic startRest(input string tag);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, tag);
    step(1'b0, 1'b0, 1'b0, tag);
    step(1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic hostStart();
    step(1'b1, 1'b0, 1'b0, "R2");
    startRest("R2");
  endtask

  task automatic selfStart(input logic [16:0] newReq);
    step(1'b0, 1'b0, 1'b0, "R8");
    reqIn = newReq;
    step(1'b0, 1'b1, 1'b0, "R8");
    startRest("R8");
  endtask

  task automatic dataFrames(input logic [16:0] snapVal, input int changeAt, input logic [16:0] newReq);
    for (int f = 1; f <= 17; f++) begin
      logic  b;
      string tag;
      if (f == changeAt) reqIn = newReq;
      b = snapVal[f-1] && (f != 1) && (f != 17);
      if (f == 1 || f == 17)  tag = "R5";
      else if (changeAt != 0) tag = "R6";
      else if (b)             tag = "R3";
      else                    tag = "R4";
      step(1'b0, b, 1'b0, tag);
      step(1'b0, b, 1'b1, tag);
      step(1'b0, 1'b0, 1'b0, tag);
    end
  endtask

  task automatic stopFrame(input int idles, input int lows);
    idle(idles, "R7");
    for (int i = 0; i < lows; i++) step(1'b1, 1'b0, 1'b0, "R7");
    step(1'b0, 1'b0, 1'b0, "R7");
    idle(2, "R7");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (serOe !== 1'b0) begin
      errors++;
      $display("FAIL R1: oe during reset actual %b expected 0", serOe);
    end
    @(posedge clk);
    #1 rstN = 1'b1;

    idle(3, "R1");
    reqIn = 17'h1FFFF;
    idle(4, "R1");                       // continuous after reset: no self-start
    hostStart();
    dataFrames(17'h1FFFF, 0, '0);        // bits 0 and 16 stay quiet
    stopFrame(2, 2);                     // quiet next

    idle(4, "R9");                       // quiet, unchanged requests
    selfStart(17'h00005);                // SMI slot (bit 2) plus reserved bit 0
    dataFrames(17'h00005, 4, 17'h00010); // mid-cycle change must not show
    stopFrame(1, 3);                     // continuous next

    idle(4, "R9");                       // pending change, continuous mode
    hostStart();
    dataFrames(17'h00010, 0, '0);
    stopFrame(3, 1);                     // one low: mode unchanged

    reqIn = 17'h0AAAA;
    idle(4, "R7");                       // still continuous: no self-start
    hostStart();
    dataFrames(17'h0AAAA, 0, '0);
    stopFrame(1, 2);                     // quiet next

    step(1'b1, 1'b0, 1'b0, "R2");        // host start and change in one state
    reqIn = 17'h15555;
    startRest("R2");
    dataFrames(17'h15555, 0, '0);
    stopFrame(2, 4);                     // four lows: continuous next
    reqIn = 17'h00100;
    idle(4, "R7");

    wait (expQ.size() == 0);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule